// File: doc/BRIEF.md
# Oscillator Clock Quality Checker

This block keeps a chip in reset after power-on until its crystal oscillator has shown that it runs fast enough to be trusted. It runs entirely from an internal self-clock, which is always available. It divides self-clock time into fixed check windows and counts rising crystal edges inside each one. The crystal is brought into the self-clock domain through a small synchronizer before counting. When a window collects enough edges, reset is released and the clock select moves to the crystal.

If the crystal stays too slow for a bounded number of windows in a row, the block gives up waiting. It releases reset anyway and flags self-clock mode, so the system can go on with limited operation on the internal clock. From that mode, software can ask for a fresh check. A pass moves the system onto the crystal. A further run of failures returns the block to self-clock mode.

A power-on flag records that a power-on reset occurred. Only an explicit clear input removes it. A status output reports whether the most recent check passed or timed out.

Top module: `osc_qual_check`

## Requirements
- R1: While `porN` is low, the outputs are `rstHold`=1, `clkSelXtal`=0, `selfClkMode`=0, `chkStatus`=0 and `porFlag`=1.
- R2: A check window lasts `WIN_LEN` self-clock cycles. The first window starts at the first self-clock rising edge after `porN` goes high. The pass/fail decision for window k appears on the outputs right after rising edge k·`WIN_LEN`, counting from that release, and not earlier.
- R3: A window passes when at least `PASS_EDGES` rising crystal edges are seen in it. A pass sets `rstHold`=0, `clkSelXtal`=1, `selfClkMode`=0 and `chkStatus`=1.
- R4: The crystal edge count starts from zero in every window. Edges seen in earlier windows never help a later window pass.
- R5: After a failing window that is not the `MAX_WIN`-th failure in a row, `rstHold` stays 1 and a new window starts at once.
- R6: After `MAX_WIN` failing windows in a row, the outputs become `rstHold`=0, `selfClkMode`=1, `clkSelXtal`=0 and `chkStatus`=0.
- R7: In self-clock mode, `startReq`=1 at a rising edge starts a new check with a fresh failure count. The first window begins on the next cycle. `rstHold` stays 0 and `selfClkMode` stays 1 while the check runs. A pass gives `clkSelXtal`=1, `selfClkMode`=0 and `chkStatus`=1.
- R8: If a software-started check fails `MAX_WIN` windows in a row, the block returns to self-clock mode with `chkStatus`=0 and `rstHold`=0. After that, a new `startReq` is needed to start another check.
- R9: `startReq` has no effect during the power-on check, during a software-started check, or once the crystal has been selected. The crystal selection holds until the next power-on reset.
- R10: `porFlag` is set only by power-on reset. It is cleared only by `porFlagClr`=1 at a rising edge, and no other activity changes it.
- R11: `clkSelXtal` and `selfClkMode` are never 1 together, and `clkSelXtal`=1 only while `rstHold`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| selfClk | input | 1 | Internal self-clock; every register runs on it |
| xtalClk | input | 1 | Crystal oscillator clock, asynchronous to selfClk |
| porN | input | 1 | Power-on reset, active low, asynchronous assert |
| startReq | input | 1 | Software request to re-check the crystal from self-clock mode |
| porFlagClr | input | 1 | Software clear of the power-on flag |
| rstHold | output | 1 | 1 holds the system in reset |
| clkSelXtal | output | 1 | 1 selects the crystal as system clock, 0 the self-clock |
| selfClkMode | output | 1 | 1 while the system runs from the self-clock after a timeout |
| chkStatus | output | 1 | 1 if the last completed check passed, 0 if it timed out or none finished |
| porFlag | output | 1 | Power-on reset occurred and has not yet been cleared |

## Verification
The hardest situation to reach from the ports is a crystal that counts too few edges in any single window but enough across two windows. Only that case shows whether the count restarts each window. The stimulus runs the crystal at a period that gives about nine edges per window against a threshold of sixteen, so a block that accumulates would pass in the second window. A second hard case is a crystal that is silent in the first window and fast in the second, which must pass exactly at the second boundary. Whether a software-started check has ended and returned to self-clock mode cannot be seen directly, because the outputs look the same. The bench therefore issues another request after the timeout and checks that the pass lands exactly one window later.

// File: rtl/oqc_pkg.sv
package oqc_pkg;

  typedef enum logic [1:0] {
    ST_PORCHK = 2'd0,
    ST_RECHK  = 2'd1,
    ST_RUNX   = 2'd2,
    ST_SELF   = 2'd3
  } oqcState_t;

  typedef struct packed {
    logic winRun;
    logic winClr;
    logic failInc;
    logic failClr;
  } oqcStrobe_t;

endpackage

// File: rtl/oqc_sync.sv
module oqc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] stageQ;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[0] <= 1'b0;
          else       stageQ[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[i] <= 1'b0;
          else       stageQ[i] <= stageQ[i-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/oqc_datapath.sv
module oqc_datapath
  import oqc_pkg::*;
#(
  parameter int WIN_LEN     = 50000,
  parameter int PASS_EDGES  = 4096,
  parameter int MAX_WIN     = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       xtalClk,
  input  oqcStrobe_t strb,
  output logic       winEnd,
  output logic       winPass,
  output logic       failLast
);

  localparam int WIN_W  = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
  localparam int EDGE_W = $clog2(PASS_EDGES + 1);
  localparam int SUM_W  = EDGE_W + 1;
  localparam int FAIL_W = $clog2(MAX_WIN + 1);

  logic              xtalSync;
  logic              xtalPrev;
  logic              edgePulse;
  logic [WIN_W-1:0]  winCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [SUM_W-1:0]  edgeSum;
  logic [FAIL_W-1:0] failCnt;

  oqc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (xtalClk),
    .syncOut (xtalSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) xtalPrev <= 1'b0;
    else       xtalPrev <= xtalSync;
  end

  assign edgePulse = xtalSync & ~xtalPrev;

  assign winEnd   = (winCnt == WIN_W'(WIN_LEN - 1));
  assign edgeSum  = {1'b0, edgeCnt} + SUM_W'(edgePulse);
  assign winPass  = (edgeSum >= SUM_W'(PASS_EDGES));
  assign failLast = (failCnt == FAIL_W'(MAX_WIN - 1));

  // window and edge counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      edgeCnt <= '0;
    end else if (strb.winClr) begin
      winCnt  <= '0;
      edgeCnt <= '0;
    end else if (strb.winRun) begin
      if (winEnd) begin
        winCnt  <= '0;
        edgeCnt <= '0;
      end else begin
        winCnt <= winCnt + WIN_W'(1);
        if (edgePulse && (edgeCnt != EDGE_W'(PASS_EDGES)))
          edgeCnt <= edgeCnt + EDGE_W'(1);
      end
    end
  end

  // consecutive failed windows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             failCnt <= '0;
    else if (strb.failClr) failCnt <= '0;
    else if (strb.failInc) failCnt <= failCnt + FAIL_W'(1);
  end

endmodule

// File: rtl/oqc_control.sv
module oqc_control
  import oqc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       porFlagClr,
  input  logic       winEnd,
  input  logic       winPass,
  input  logic       failLast,
  output oqcStrobe_t strb,
  output logic       rstHold,
  output logic       clkSelXtal,
  output logic       selfClkMode,
  output logic       chkStatus,
  output logic       porFlag
);

  oqcState_t stateQ, stateD;
  logic      statusQ, statusD;
  logic      porFlagQ;

  always_comb begin
    stateD  = stateQ;
    statusD = statusQ;
    strb    = '0;
    unique case (stateQ)
      ST_PORCHK, ST_RECHK: begin
        strb.winRun = 1'b1;
        if (winEnd) begin
          if (winPass) begin
            stateD       = ST_RUNX;
            statusD      = 1'b1;
            strb.failClr = 1'b1;
          end else if (failLast) begin
            stateD       = ST_SELF;
            statusD      = 1'b0;
            strb.failClr = 1'b1;
          end else begin
            strb.failInc = 1'b1;
          end
        end
      end
      ST_SELF: begin
        if (startReq) begin
          stateD       = ST_RECHK;
          strb.winClr  = 1'b1;
          strb.failClr = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_PORCHK;
      statusQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      statusQ <= statusD;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           porFlagQ <= 1'b1;
    else if (porFlagClr) porFlagQ <= 1'b0;
  end

  assign rstHold     = (stateQ == ST_PORCHK);
  assign clkSelXtal  = (stateQ == ST_RUNX);
  assign selfClkMode = (stateQ == ST_SELF) || (stateQ == ST_RECHK);
  assign chkStatus   = statusQ;
  assign porFlag     = porFlagQ;

endmodule

// File: rtl/osc_qual_check.sv
module osc_qual_check
  import oqc_pkg::*;
#(
  parameter int WIN_LEN     = 50000,
  parameter int PASS_EDGES  = 4096,
  parameter int MAX_WIN     = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic selfClk,
  input  logic xtalClk,
  input  logic porN,
  input  logic startReq,
  input  logic porFlagClr,
  output logic rstHold,
  output logic clkSelXtal,
  output logic selfClkMode,
  output logic chkStatus,
  output logic porFlag
);

  oqcStrobe_t strb;
  logic       winEnd;
  logic       winPass;
  logic       failLast;

  oqc_datapath #(
    .WIN_LEN     (WIN_LEN),
    .PASS_EDGES  (PASS_EDGES),
    .MAX_WIN     (MAX_WIN),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (selfClk),
    .rstN     (porN),
    .xtalClk  (xtalClk),
    .strb     (strb),
    .winEnd   (winEnd),
    .winPass  (winPass),
    .failLast (failLast)
  );

  oqc_control u_ctl (
    .clk         (selfClk),
    .rstN        (porN),
    .startReq    (startReq),
    .porFlagClr  (porFlagClr),
    .winEnd      (winEnd),
    .winPass     (winPass),
    .failLast    (failLast),
    .strb        (strb),
    .rstHold     (rstHold),
    .clkSelXtal  (clkSelXtal),
    .selfClkMode (selfClkMode),
    .chkStatus   (chkStatus),
    .porFlag     (porFlag)
  );

endmodule

// File: rtl/oqc_checker.sv
module oqc_checker (
  input logic selfClk,
  input logic porN,
  input logic porFlagClr,
  input logic rstHold,
  input logic clkSelXtal,
  input logic selfClkMode,
  input logic chkStatus,
  input logic porFlag
);

  // R11
  mode_excl_chk: assert property (@(posedge selfClk) disable iff (!porN)
    !(clkSelXtal && selfClkMode));

  // R11
  xtal_rst_chk: assert property (@(posedge selfClk) disable iff (!porN)
    clkSelXtal |-> !rstHold);

  // R3
  pass_status_chk: assert property (@(posedge selfClk) disable iff (!porN)
    $rose(clkSelXtal) |-> chkStatus);

  // R6
  timeout_out_chk: assert property (@(posedge selfClk) disable iff (!porN)
    $rose(selfClkMode) |-> (!chkStatus && !rstHold));

  // R5
  rst_once_chk: assert property (@(posedge selfClk) disable iff (!porN)
    !$rose(rstHold));

  // R9
  xtal_hold_chk: assert property (@(posedge selfClk) disable iff (!porN)
    clkSelXtal |=> clkSelXtal);

  // R10
  porfl_hold_chk: assert property (@(posedge selfClk) disable iff (!porN)
    (porFlag && !porFlagClr) |=> porFlag);

  // R10
  porfl_norise_chk: assert property (@(posedge selfClk) disable iff (!porN)
    !$rose(porFlag));

endmodule

bind osc_qual_check oqc_checker u_chk (
  .selfClk     (selfClk),
  .porN        (porN),
  .porFlagClr  (porFlagClr),
  .rstHold     (rstHold),
  .clkSelXtal  (clkSelXtal),
  .selfClkMode (selfClkMode),
  .chkStatus   (chkStatus),
  .porFlag     (porFlag)
);

// File: tb/sim_osc_qual_check.sv
`timescale 1ns/1ps
module sim_osc_qual_check;

  localparam int WIN = 64;
  localparam int PASSN = 16;
  localparam int MAXW = 3;

  // output codes {rstHold, clkSelXtal, selfClkMode, chkStatus}
  localparam logic [3:0] O_RST  = 4'b1000;
  localparam logic [3:0] O_XTAL = 4'b0101;
  localparam logic [3:0] O_SELF = 4'b0010;

  // crystal half period in 0.1 ns (0 = stopped), expected pass
  localparam int NVEC = 6;
  localparam int VEC_HALF [NVEC] = '{115, 0, 350, 135, 260, 155};
  localparam bit VEC_PASS [NVEC] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  logic selfClk = 1'b0;
  logic xtalClk = 1'b0;
  logic porN = 1'b0;
  logic startReq = 1'b0;
  logic porFlagClr = 1'b0;
  logic rstHold, clkSelXtal, selfClkMode, chkStatus, porFlag;
  int   xHalfT = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   done = 1'b0;

  osc_qual_check #(.WIN_LEN(WIN), .PASS_EDGES(PASSN), .MAX_WIN(MAXW)) u0 (
    .selfClk(selfClk), .xtalClk(xtalClk), .porN(porN), .startReq(startReq),
    .porFlagClr(porFlagClr), .rstHold(rstHold), .clkSelXtal(clkSelXtal),
    .selfClkMode(selfClkMode), .chkStatus(chkStatus), .porFlag(porFlag));

  always #5 selfClk = ~selfClk;

  always begin
    if (xHalfT == 0) begin
      xtalClk = 1'b0;
      #1;
    end else begin
      #(xHalfT * 0.1);
      xtalClk = ~xtalClk;
    end
  end

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s outputs actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkFlag(input string req, input logic exp);
    nChecks++;
    if (porFlag !== exp) begin
      nFails++;
      $display("FAIL %s porFlag actual=%b expected=%b at %0t", req, porFlag, exp, $time);
    end
  endtask

  function automatic logic [3:0] outs();
    return {rstHold, clkSelXtal, selfClkMode, chkStatus};
  endfunction

  // applies power-on reset and releases at a falling edge
  task automatic doPor(input int half);
    @(negedge selfClk);
    porN = 1'b0;
    xHalfT = half;
    repeat (3) @(negedge selfClk);
    porN = 1'b1;
  endtask

  // advance n rising edges, then sample at the following falling edge
  task automatic stepN(input int n);
    repeat (n) @(posedge selfClk);
    @(negedge selfClk);
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    @(posedge selfClk);
    @(negedge selfClk);
    startReq = 1'b0;
  endtask

  initial begin
    #1;
    // R1 reset state
    #20;
    chk("R1", outs(), O_RST);
    chkFlag("R1", 1'b1);

    // vector table: R2 R3 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      doPor(VEC_HALF[v]);
      chk("R1", outs(), O_RST);
      if (VEC_PASS[v]) begin
        stepN(WIN - 1);
        chk("R2", outs(), O_RST);
        stepN(0);
        @(posedge selfClk); @(negedge selfClk);
        chk("R3", outs(), O_XTAL);
      end else begin
        stepN(WIN);
        chk("R5", outs(), O_RST);
        stepN(MAXW * WIN - WIN - 1);
        chk("R2", outs(), O_RST);
        @(posedge selfClk); @(negedge selfClk);
        chk("R6", outs(), O_SELF);
      end
    end

    // R4: about nine edges per window must never pass (350 entry above) ; R5 then R3
    doPor(0);
    stepN(WIN);
    chk("R5", outs(), O_RST);
    xHalfT = 115;
    stepN(WIN - 1);
    chk("R4", outs(), O_RST);
    @(posedge selfClk); @(negedge selfClk);
    chk("R3", outs(), O_XTAL);

    // R9: start request during the power-on check and after crystal selection
    doPor(115);
    stepN(10);
    pulseStart();
    stepN(WIN - 12);
    chk("R9", outs(), O_RST);
    @(posedge selfClk); @(negedge selfClk);
    chk("R9", outs(), O_XTAL);
    pulseStart();
    stepN(2 * WIN);
    chk("R9", outs(), O_XTAL);
    // R10 clear
    chkFlag("R10", 1'b1);
    porFlagClr = 1'b1;
    @(posedge selfClk); @(negedge selfClk);
    porFlagClr = 1'b0;
    chkFlag("R10", 1'b0);

    // R7: recheck from self-clock mode passes
    doPor(0);
    chkFlag("R10", 1'b1);
    porFlagClr = 1'b1;
    @(posedge selfClk); @(negedge selfClk);
    porFlagClr = 1'b0;
    stepN(MAXW * WIN - 1);
    chk("R6", outs(), O_SELF);
    xHalfT = 115;
    pulseStart();
    chk("R7", outs(), O_SELF);
    stepN(WIN - 1);
    chk("R7", outs(), O_SELF);
    @(posedge selfClk); @(negedge selfClk);
    chk("R7", outs(), O_XTAL);
    chkFlag("R10", 1'b0);

    // R8: recheck that times out, then start request during recheck ignored
    doPor(0);
    stepN(MAXW * WIN);
    chk("R6", outs(), O_SELF);
    pulseStart();
    stepN(WIN);
    pulseStart();
    stepN(MAXW * WIN - WIN - 3);
    chk("R8", outs(), O_SELF);
    xHalfT = 115;
    stepN(4);
    chk("R8", outs(), O_SELF);
    pulseStart();
    stepN(WIN - 1);
    chk("R8", outs(), O_SELF);
    @(posedge selfClk); @(negedge selfClk);
    chk("R8", outs(), O_XTAL);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

endmodule